// File: doc/BRIEF.md
# SIMD Element Insert Unit

This unit executes the integer element insert into a 128-bit vector register. It takes the opcode bytes and prefix flags of one instruction, an 8-bit immediate, a 64-bit general-purpose source and the current value of the destination vector register. It writes an 8-bit, 32-bit or 64-bit value from the source into one lane of that register and leaves every other lane unchanged.

Decode, fault checking and the lane merge are all combinational. One output register stage follows them, so a result appears one cycle after its input strobe. The result comes with a write-enable and a 4-bit destination register index. A fault replaces the write with one of two indications: invalid-opcode or device-not-available. The unit produces no status-flag outputs.

Top module: `vec_lane_insert`

## Requirements
- R1: An operand-size prefix (`pfx_66`=1) followed by bytes 0x0F, 0x3A, 0x20 selects the byte insert, and REX.W is ignored for it. The same escape followed by 0x22 selects the 32-bit insert when `rex_w`=0 and the 64-bit insert when `rex_w`=1. Any other byte sequence, or a missing operand-size prefix, raises invalid-opcode.
- R2: The 64-bit insert raises invalid-opcode when `long_mode`=0. The 32-bit and byte inserts are legal in either mode.
- R3: The lane number is taken from `imm8[3:0]` for the byte insert (16 lanes), from `imm8[1:0]` for the 32-bit insert (4 lanes) and from `imm8[0]` for the 64-bit insert (2 lanes). Lane n occupies bits starting at n × element width. Higher immediate bits have no effect.
- R4: The byte insert writes only `gpr_src[7:0]`. Source bits 63:8 have no effect on the result.
- R5: The result equals the destination with the selected lane replaced by the source element. All other lanes keep their destination value.
- R6: `out_reg_idx` equals {`rex_r`, `modrm_reg`} of the accepted instruction, so registers 8 to 15 are reachable.
- R7: Invalid-opcode is raised whenever `cr_em`=1, `cr_osfxsr`=0, `feat_en`=0, `pfx_lock`=1, `pfx_f2`=1 or `pfx_f3`=1.
- R8: Device-not-available is raised when `cr_ts`=1 and no invalid-opcode condition holds. Invalid-opcode takes priority, and the two are never raised together.
- R9: When either fault is raised, `out_wen`=0 and `out_result` equals the unmodified destination value.
- R10: `out_valid` is high exactly one cycle after `in_valid`. Without a strobe, `out_valid`, `out_wen`, `out_ud` and `out_nm` are low. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| pfx_66 | input | 1 | Operand-size prefix present |
| opc_esc0 | input | 8 | First opcode byte |
| opc_esc1 | input | 8 | Second opcode byte |
| opc_main | input | 8 | Third opcode byte |
| rex_w | input | 1 | REX.W bit |
| rex_r | input | 1 | REX.R bit |
| pfx_lock | input | 1 | LOCK prefix present |
| pfx_f2 | input | 1 | F2 prefix present |
| pfx_f3 | input | 1 | F3 prefix present |
| modrm_reg | input | 3 | ModRM reg field |
| imm8 | input | 8 | Immediate lane selector |
| gpr_src | input | 64 | General-purpose source value |
| vec_dst | input | 128 | Current destination vector value |
| long_mode | input | 1 | Processor is in 64-bit mode |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_osfxsr | input | 1 | OS vector-state support bit |
| feat_en | input | 1 | Feature enabled |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Merged vector value |
| out_wen | output | 1 | Register write-enable |
| out_reg_idx | output | 4 | Destination register index |
| out_ud | output | 1 | Invalid-opcode fault |
| out_nm | output | 1 | Device-not-available fault |

## Verification
The merge is swept over all 256 immediate values for each of the three element sizes, with fresh random source and destination words for every value. An off-by-one in a lane shift, a wrong selector width, or a leak of upper immediate bits each show up as a lane mismatch. Upper source bits are always non-zero, which separates a byte insert that takes only bits 7:0 from one that copies a wider slice. All 64 combinations of the six invalid-opcode conditions are applied, each with task-switched both clear and set, which tests the fault priority and the suppressed write. Directed opcode cases exercise a wrong opcode byte, a missing prefix, REX.W on the byte form and the long-mode restriction on the 64-bit form.

// File: rtl/vli_pkg.sv
`timescale 1ns/1ps
package vli_pkg;

   typedef enum logic [1:0] {
      INS_NONE  = 2'd0,
      INS_BYTE  = 2'd1,
      INS_DWORD = 2'd2,
      INS_QWORD = 2'd3
   } ins_kind_e;

   localparam logic [7:0] OPC_ESC0 = 8'h0F;
   localparam logic [7:0] OPC_ESC1 = 8'h3A;
   localparam logic [7:0] OPC_BYTE = 8'h20;
   localparam logic [7:0] OPC_WIDE = 8'h22;

   typedef struct packed {
      ins_kind_e kind;
      logic      ud;
      logic      nm;
   } dec_t;

endpackage

// File: rtl/vli_decode.sv
`timescale 1ns/1ps
module vli_decode
   import vli_pkg::*;
(
   input  logic       pfx_66,
   input  logic [7:0] opc_esc0,
   input  logic [7:0] opc_esc1,
   input  logic [7:0] opc_main,
   input  logic       rex_w,
   input  logic       pfx_lock,
   input  logic       pfx_f2,
   input  logic       pfx_f3,
   input  logic       long_mode,
   input  logic       cr_em,
   input  logic       cr_ts,
   input  logic       cr_osfxsr,
   input  logic       feat_en,
   output dec_t       dec
);

   logic      esc_ok;
   ins_kind_e kind;
   logic      env_bad;
   logic      mode_bad;

   assign esc_ok = pfx_66 && (opc_esc0 == OPC_ESC0) && (opc_esc1 == OPC_ESC1);

   always_comb begin
      kind = INS_NONE;
      if (esc_ok && (opc_main == OPC_BYTE)) begin
         kind = INS_BYTE;
      end else if (esc_ok && (opc_main == OPC_WIDE)) begin
         kind = rex_w ? INS_QWORD : INS_DWORD;
      end
   end

   // Environment and prefix conditions that forbid execution
   assign env_bad  = cr_em || !cr_osfxsr || !feat_en || pfx_lock || pfx_f2 || pfx_f3;
   assign mode_bad = (kind == INS_QWORD) && !long_mode;

   always_comb begin
      dec.kind = kind;
      dec.ud   = (kind == INS_NONE) || mode_bad || env_bad;
      dec.nm   = cr_ts && !dec.ud;
   end

endmodule

// File: rtl/vli_lane_merge.sv
`timescale 1ns/1ps
module vli_lane_merge
   import vli_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int GPR_W = 64
)(
   input  ins_kind_e        kind,
   input  logic [7:0]       imm8,
   input  logic [GPR_W-1:0] src,
   input  logic [VEC_W-1:0] dst,
   output logic [VEC_W-1:0] res
);

   localparam int NBYTES = VEC_W / 8;
   localparam int DBYTES = 4;
   localparam int QBYTES = GPR_W / 8;
   localparam int BSEL_W = $clog2(NBYTES);
   localparam int DSEL_W = $clog2(VEC_W / 32);
   localparam int QSEL_W = $clog2(VEC_W / GPR_W);

   logic [BSEL_W-1:0] bsel;
   logic [DSEL_W-1:0] dsel;
   logic [QSEL_W-1:0] qsel;
   logic              unused_imm;

   assign bsel       = imm8[BSEL_W-1:0];
   assign dsel       = imm8[DSEL_W-1:0];
   assign qsel       = imm8[QSEL_W-1:0];
   assign unused_imm = ^imm8[7:BSEL_W];

   // Each destination byte chooses between its old value and a source byte
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam logic [BSEL_W-1:0] B_LANE = BSEL_W'(b);
      localparam logic [DSEL_W-1:0] D_LANE = DSEL_W'(b / DBYTES);
      localparam logic [QSEL_W-1:0] Q_LANE = QSEL_W'(b / QBYTES);
      localparam int D_OFS = (b % DBYTES) * 8;
      localparam int Q_OFS = (b % QBYTES) * 8;

      logic       hit;
      logic [7:0] ins;

      always_comb begin
         case (kind)
            INS_BYTE: begin
               hit = (bsel == B_LANE);
               ins = src[7:0];
            end
            INS_DWORD: begin
               hit = (dsel == D_LANE);
               ins = src[D_OFS +: 8];
            end
            INS_QWORD: begin
               hit = (qsel == Q_LANE);
               ins = src[Q_OFS +: 8];
            end
            default: begin
               hit = 1'b0;
               ins = 8'h00;
            end
         endcase
      end

      assign res[b*8 +: 8] = hit ? ins : dst[b*8 +: 8];
   end

endmodule

// File: rtl/vec_lane_insert.sv
`timescale 1ns/1ps
module vec_lane_insert
   import vli_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int GPR_W = 64,
   parameter int RIDX_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              pfx_66,
   input  logic [7:0]        opc_esc0,
   input  logic [7:0]        opc_esc1,
   input  logic [7:0]        opc_main,
   input  logic              rex_w,
   input  logic              rex_r,
   input  logic              pfx_lock,
   input  logic              pfx_f2,
   input  logic              pfx_f3,
   input  logic [RIDX_W-2:0] modrm_reg,
   input  logic [7:0]        imm8,
   input  logic [GPR_W-1:0]  gpr_src,
   input  logic [VEC_W-1:0]  vec_dst,
   input  logic              long_mode,
   input  logic              cr_em,
   input  logic              cr_ts,
   input  logic              cr_osfxsr,
   input  logic              feat_en,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_result,
   output logic              out_wen,
   output logic [RIDX_W-1:0] out_reg_idx,
   output logic              out_ud,
   output logic              out_nm
);

   // Elaboration-time parameter checks
   if (GPR_W < 32 || (GPR_W & (GPR_W - 1)) != 0) begin : g_bad_gpr
      $error("GPR_W must be a power of two of at least 32");
   end
   if (VEC_W < 2 * GPR_W || VEC_W > 1024 || (VEC_W & (VEC_W - 1)) != 0) begin : g_bad_vec
      $error("VEC_W must be a power of two between 2*GPR_W and 1024");
   end
   if (RIDX_W < 2) begin : g_bad_ridx
      $error("RIDX_W must be at least 2");
   end

   dec_t             dec;
   logic [VEC_W-1:0] merged;
   logic             fault;

   vli_decode u_decode (
      .pfx_66    (pfx_66),
      .opc_esc0  (opc_esc0),
      .opc_esc1  (opc_esc1),
      .opc_main  (opc_main),
      .rex_w     (rex_w),
      .pfx_lock  (pfx_lock),
      .pfx_f2    (pfx_f2),
      .pfx_f3    (pfx_f3),
      .long_mode (long_mode),
      .cr_em     (cr_em),
      .cr_ts     (cr_ts),
      .cr_osfxsr (cr_osfxsr),
      .feat_en   (feat_en),
      .dec       (dec)
   );

   vli_lane_merge #(
      .VEC_W (VEC_W),
      .GPR_W (GPR_W)
   ) u_merge (
      .kind (dec.kind),
      .imm8 (imm8),
      .src  (gpr_src),
      .dst  (vec_dst),
      .res  (merged)
   );

   assign fault = dec.ud || dec.nm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_wen     <= 1'b0;
         out_ud      <= 1'b0;
         out_nm      <= 1'b0;
         out_result  <= '0;
         out_reg_idx <= '0;
      end else begin
         out_valid <= in_valid;
         out_wen   <= in_valid && !fault;
         out_ud    <= in_valid && dec.ud;
         out_nm    <= in_valid && dec.nm;
         if (in_valid) begin
            out_reg_idx <= {rex_r, modrm_reg};
            out_result  <= fault ? vec_dst : merged;
         end
      end
   end

endmodule

// File: rtl/vli_insert_chk.sv
`timescale 1ns/1ps
module vli_insert_chk #(
   parameter int VEC_W = 128,
   parameter int GPR_W = 64,
   parameter int RIDX_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        opc_main,
   input logic              rex_w,
   input logic              rex_r,
   input logic              pfx_lock,
   input logic              pfx_f2,
   input logic              pfx_f3,
   input logic [RIDX_W-2:0] modrm_reg,
   input logic [VEC_W-1:0]  vec_dst,
   input logic              long_mode,
   input logic              cr_em,
   input logic              cr_ts,
   input logic              cr_osfxsr,
   input logic              feat_en,
   input logic              out_valid,
   input logic [VEC_W-1:0]  out_result,
   input logic              out_wen,
   input logic [RIDX_W-1:0] out_reg_idx,
   input logic              out_ud,
   input logic              out_nm
);

   // R10
   strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_wen && !out_ud && !out_nm));

   // R8
   fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ud |-> !out_nm);

   // R9
   fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ud || out_nm) |-> !out_wen);

   // R9
   fault_keep_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!(out_ud || out_nm) || out_result == $past(vec_dst)));

   // R6
   reg_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_reg_idx == {$past(rex_r), $past(modrm_reg)});

   // R7
   env_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (pfx_lock || pfx_f2 || pfx_f3 || cr_em || !cr_osfxsr || !feat_en))
      |=> out_ud);

   // R2
   wide_legacy_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc_main == 8'h22 && rex_w && !long_mode) |=> out_ud);

   // R8
   ts_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cr_ts) |=> (out_ud || out_nm));

endmodule

bind vec_lane_insert vli_insert_chk #(
   .VEC_W  (VEC_W),
   .GPR_W  (GPR_W),
   .RIDX_W (RIDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .opc_main    (opc_main),
   .rex_w       (rex_w),
   .rex_r       (rex_r),
   .pfx_lock    (pfx_lock),
   .pfx_f2      (pfx_f2),
   .pfx_f3      (pfx_f3),
   .modrm_reg   (modrm_reg),
   .vec_dst     (vec_dst),
   .long_mode   (long_mode),
   .cr_em       (cr_em),
   .cr_ts       (cr_ts),
   .cr_osfxsr   (cr_osfxsr),
   .feat_en     (feat_en),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_wen     (out_wen),
   .out_reg_idx (out_reg_idx),
   .out_ud      (out_ud),
   .out_nm      (out_nm)
);

// File: tb/vec_lane_insert_tb.sv
`timescale 1ns/1ps
module vec_lane_insert_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         pfx_66, rex_w, rex_r, pfx_lock, pfx_f2, pfx_f3;
   logic [7:0]   opc_esc0, opc_esc1, opc_main, imm8;
   logic [2:0]   modrm_reg;
   logic [63:0]  gpr_src;
   logic [127:0] vec_dst;
   logic         long_mode, cr_em, cr_ts, cr_osfxsr, feat_en;
   logic         out_valid, out_wen, out_ud, out_nm;
   logic [127:0] out_result;
   logic [3:0]   out_reg_idx;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   vec_lane_insert u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .pfx_66 (pfx_66),
      .opc_esc0 (opc_esc0), .opc_esc1 (opc_esc1), .opc_main (opc_main),
      .rex_w (rex_w), .rex_r (rex_r), .pfx_lock (pfx_lock), .pfx_f2 (pfx_f2),
      .pfx_f3 (pfx_f3), .modrm_reg (modrm_reg), .imm8 (imm8), .gpr_src (gpr_src),
      .vec_dst (vec_dst), .long_mode (long_mode), .cr_em (cr_em), .cr_ts (cr_ts),
      .cr_osfxsr (cr_osfxsr), .feat_en (feat_en), .out_valid (out_valid),
      .out_result (out_result), .out_wen (out_wen), .out_reg_idx (out_reg_idx),
      .out_ud (out_ud), .out_nm (out_nm)
   );

   // Expected merge, from mask arithmetic: k 0 = byte, 1 = 32-bit, 2 = 64-bit
   function automatic logic [127:0] model(int k, logic [7:0] imm, logic [63:0] s,
                                          logic [127:0] d);
      logic [127:0] m, t;
      int sel;
      case (k)
         0: begin sel = int'(imm[3:0]); m = 128'hFF << (sel*8);
                  t = 128'(s[7:0]) << (sel*8); end
         1: begin sel = int'(imm[1:0]); m = 128'hFFFF_FFFF << (sel*32);
                  t = 128'(s[31:0]) << (sel*32); end
         default: begin sel = int'(imm[0]); m = 128'hFFFF_FFFF_FFFF_FFFF << (sel*64);
                  t = 128'(s) << (sel*64); end
      endcase
      return (d & ~m) | (t & m);
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic legal_env();
      pfx_66 = 1'b1; opc_esc0 = 8'h0F; opc_esc1 = 8'h3A; opc_main = 8'h20;
      rex_w = 1'b0; rex_r = 1'b0; pfx_lock = 1'b0; pfx_f2 = 1'b0; pfx_f3 = 1'b0;
      modrm_reg = 3'd0; imm8 = 8'd0; long_mode = 1'b1; cr_em = 1'b0; cr_ts = 1'b0;
      cr_osfxsr = 1'b1; feat_en = 1'b1;
   endtask

   task automatic set_kind(input int k);
      opc_main = (k == 0) ? 8'h20 : 8'h22;
      rex_w    = (k == 2);
   endtask

   task automatic randomize_data();
      gpr_src = {$urandom, $urandom} | 64'hFF00_0000_0000_0000;
      vec_dst = {$urandom, $urandom, $urandom, $urandom};
   endtask

   // Present inputs for one cycle, then wait to the negedge after the capture edge
   task automatic fire();
      in_valid = 1'b1;
      @(negedge clk);
   endtask

   task automatic expect_ok(input string tag, input logic [127:0] exp);
      check(out_valid && out_wen && !out_ud && !out_nm && out_result == exp,
            tag, out_result, exp);
   endtask

   task automatic expect_ud(input string tag);
      check(out_valid && out_ud && !out_nm && !out_wen && out_result == vec_dst,
            tag, {out_valid, out_ud, out_nm, out_wen}, 4'b1100);
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      legal_env();
      gpr_src = '0; vec_dst = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!out_valid && !out_wen && !out_ud && !out_nm && out_result == '0 &&
            out_reg_idx == '0, "R10 reset", out_result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R10 idle after reset", 128'(out_valid), '0);

      // R3 R4 R5 R1: every immediate for every element size
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 256; i++) begin
            legal_env();
            set_kind(k);
            imm8 = 8'(i);
            randomize_data();
            fire();
            expect_ok(k == 0 ? "R4 R3 R5 byte insert" :
                      k == 1 ? "R3 R5 dword insert" : "R3 R5 qword insert",
                      model(k, 8'(i), gpr_src, vec_dst));
         end
      end

      // R6 destination index
      for (int r = 0; r < 16; r++) begin
         legal_env();
         rex_r = r[3]; modrm_reg = r[2:0];
         randomize_data();
         fire();
         check(out_reg_idx == 4'(r) && out_wen, "R6 reg index", 128'(out_reg_idx), 128'(r));
      end

      // R7 R8 R9 every invalid-opcode condition combination, with and without TS
      for (int m = 0; m < 64; m++) begin
         for (int ts = 0; ts < 2; ts++) begin
            legal_env();
            set_kind(m % 3);
            cr_em = m[0]; cr_osfxsr = !m[1]; feat_en = !m[2];
            pfx_lock = m[3]; pfx_f2 = m[4]; pfx_f3 = m[5];
            cr_ts = ts[0];
            imm8 = 8'(m);
            randomize_data();
            fire();
            if (m != 0) expect_ud("R7 R8 R9 env fault");
            else if (ts != 0)
               check(out_valid && out_nm && !out_ud && !out_wen && out_result == vec_dst,
                     "R8 R9 ts fault", out_result, vec_dst);
            else expect_ok("R7 clean env", model(m % 3, 8'(m), gpr_src, vec_dst));
         end
      end

      // R1 decode corner cases
      legal_env(); randomize_data(); pfx_66 = 1'b0;
      fire(); expect_ud("R1 missing prefix");
      legal_env(); randomize_data(); opc_main = 8'h21;
      fire(); expect_ud("R1 bad opcode");
      legal_env(); randomize_data(); opc_esc1 = 8'h38;
      fire(); expect_ud("R1 bad escape");
      legal_env(); randomize_data(); rex_w = 1'b1; imm8 = 8'h1B;
      fire(); expect_ok("R1 byte ignores W", model(0, 8'h1B, gpr_src, vec_dst));

      // R2 long-mode restriction
      legal_env(); randomize_data(); set_kind(2); long_mode = 1'b0; imm8 = 8'h01;
      fire(); expect_ud("R2 qword outside long mode");
      legal_env(); randomize_data(); set_kind(1); long_mode = 1'b0; imm8 = 8'h03;
      fire(); expect_ok("R2 dword outside long mode", model(1, 8'h03, gpr_src, vec_dst));
      legal_env(); randomize_data(); set_kind(0); long_mode = 1'b0; imm8 = 8'h0F;
      fire(); expect_ok("R2 byte outside long mode", model(0, 8'h0F, gpr_src, vec_dst));

      // R10 no strobe, no output activity
      in_valid = 1'b0;
      @(negedge clk);
      check(!out_valid && !out_wen && !out_ud && !out_nm, "R10 idle",
            {out_valid, out_wen, out_ud, out_nm}, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule